// File: doc/BRIEF.md
# Cross-Node Interrupt Register Hub

This block is a small register file shared by four processor nodes on a common bus. Any node can ring a per-node doorbell to interrupt any other node, or silence it again. A status word lets a node find out why its combined interrupt fired. The status word holds the doorbell bits, a sticky bus-error flag per node, and the three active-low priority-level lines of the backplane bus controller. An enable register decides, node by node, whether the controller's interrupt reaches that node. An identification register gives each node one bit that only that node may change, so software can tell which node it is running on.

Every register access carries the number of the node making it (0 = node A through 3 = node D). The hub also combines raw external lines into active-high processor inputs. Each node's two active-low mezzanine interrupt lines become one high-level signal with no latching. The four active-low expansion-link lines become one interrupt that goes only to node A.

Top module: `xnode_irq_hub`

## Requirements
- R1: While `rst` is high at a clock edge, all doorbell, bus-error, enable and identification bits become 0. With the controller lines idle (`ctrl_ipl_n` = 3'b111), `node_irq` is then 4'b0000.
- R2: Node k's doorbell lives at byte offset 0x04 + 4·k. A write takes effect at the next clock edge: data bit 0 = 1 raises the doorbell and data bit 0 = 0 clears it. Other data bits are ignored, and a read returns the doorbell in bit 0.
- R3: A read at offset 0x00 returns `ctrl_ipl_n` in bits [2:0], the doorbells of nodes 0..3 in bits [11:8], the bus-error flags of nodes 0..3 in bits [19:16], and 0 in every other bit. Read data follows `reg_addr` in the same cycle.
- R4: A high `bus_err_set[k]` at a clock edge sets node k's bus-error flag, which then stays set until it is cleared.
- R5: A write of exactly 0x00000010 to offset 0x00 clears the bus-error flag of the requesting node only. Any other write to offset 0x00 changes nothing. If a set and a clear reach the same flag in one cycle, the flag ends up set.
- R6: Offset 0x14 holds one enable bit per node in bits [3:0]. The controller interrupt is active when `ctrl_ipl_n` is not 3'b111, and it reaches `node_irq[k]` only while enable bit k is 1. The enable bits do not gate the bus-error flags.
- R7: Offset 0x1C holds one identification bit per node in bits [3:0], and every node can read all four. A write from node n updates bit n only; the other bits keep their values.
- R8: `node_irq[k]` is the OR of node k's doorbell, node k's bus-error flag, and the enabled controller interrupt.
- R9: `mezz_irq[k]` is high whenever `mezz_int_n[2k]` or `mezz_int_n[2k+1]` is low, and it follows these lines combinationally with no latching.
- R10: `link_irq` (routed to node A) is high whenever any bit of `link_int_n` is low.
- R11: Offsets other than 0x00, 0x04–0x10, 0x14 and 0x1C read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_node | input | 2 | Number of the requesting node (0 = A … 3 = D) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| bus_err_set | input | 4 | Per-node pulse: the last controller access failed |
| ctrl_ipl_n | input | 3 | Controller interrupt priority level, active low |
| mezz_int_n | input | 8 | Two active-low mezzanine interrupts per node |
| link_int_n | input | 4 | Active-low expansion-link interrupts |
| node_irq | output | 4 | Combined interrupt to each node |
| mezz_irq | output | 4 | Per-node mezzanine interrupt, active high |
| link_irq | output | 1 | Expansion-link interrupt to node A |

## Verification
The hardest case to produce is a collision on one bus-error flag, where a new failure pulse and the owning node's clear write land on the same clock edge. The bench drives `bus_err_set` and the 0x10 status write together in one write window and checks that the flag survives. Two near misses are also tried: a clear from a node that does not own the flag, and a write of 0x11, which must not count as a clear. The write-only-own-bit rule of the identification register is exercised by having one node write all ones and then all zeros. After each write, the other nodes' bits are read back.

// File: rtl/xnih_pkg.sv
package xnih_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IPL_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DB_BASE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ID      = 8'h1C;

    localparam logic [DATA_W-1:0] BERR_CLEAR_KEY = 32'h0000_0010;

    localparam int unsigned ST_IPL_LSB = 0;
    localparam int unsigned ST_DB_LSB  = 8;
    localparam int unsigned ST_ERR_LSB = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_DOORBELL,
        SEL_ENABLE,
        SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic [ADDR_W-1:0] doorbell_ofs(input int unsigned k);
        return OFS_DB_BASE + ADDR_W'(4 * k);
    endfunction

    function automatic logic ipl_active(input logic [IPL_W-1:0] ipl_n);
        return ~&ipl_n;
    endfunction

endpackage

// File: rtl/xnih_decode.sv
module xnih_decode
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES = 4,
    localparam int unsigned IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  db_idx
);

    always_comb begin
        sel    = SEL_NONE;
        db_idx = '0;
        if (addr == OFS_STATUS) begin
            sel = SEL_STATUS;
        end else if (addr == OFS_ENABLE) begin
            sel = SEL_ENABLE;
        end else if (addr == OFS_ID) begin
            sel = SEL_ID;
        end
        for (int unsigned k = 0; k < N_NODES; k++) begin
            if (addr == doorbell_ofs(k)) begin
                sel    = SEL_DOORBELL;
                db_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/xnih_doorbells.sv
module xnih_doorbells
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES = 4,
    localparam int unsigned IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            req,
    input  reg_sel_e           sel,
    input  logic [IDX_W-1:0]   db_idx,
    output logic [N_NODES-1:0] db_q
);

    for (genvar k = 0; k < N_NODES; k++) begin : g_bell
        logic hit;
        assign hit = req.wr && (sel == SEL_DOORBELL) && (db_idx == IDX_W'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                db_q[k] <= 1'b0;
            end else if (hit) begin
                db_q[k] <= req.data[0];
            end
        end
    end

endmodule

// File: rtl/xnih_buserr.sv
module xnih_buserr
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES = 4,
    localparam int unsigned IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            req,
    input  reg_sel_e           sel,
    input  logic [IDX_W-1:0]   node,
    input  logic [N_NODES-1:0] err_set,
    output logic [N_NODES-1:0] err_q
);

    logic clr_req;
    assign clr_req = req.wr && (sel == SEL_STATUS) && (req.data == BERR_CLEAR_KEY);

    for (genvar k = 0; k < N_NODES; k++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst) begin
                err_q[k] <= 1'b0;
            end else if (err_set[k]) begin
                err_q[k] <= 1'b1;
            end else if (clr_req && (node == IDX_W'(k))) begin
                err_q[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xnih_ctlregs.sv
module xnih_ctlregs
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES = 4,
    localparam int unsigned IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            req,
    input  reg_sel_e           sel,
    input  logic [IDX_W-1:0]   node,
    output logic [N_NODES-1:0] en_q,
    output logic [N_NODES-1:0] id_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req.wr && (sel == SEL_ENABLE)) begin
            en_q <= req.data[N_NODES-1:0];
        end
    end

    for (genvar k = 0; k < N_NODES; k++) begin : g_id
        logic own_wr;
        assign own_wr = req.wr && (sel == SEL_ID) && (node == IDX_W'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                id_q[k] <= 1'b0;
            end else if (own_wr) begin
                id_q[k] <= req.data[k];
            end
        end
    end

endmodule

// File: rtl/xnih_extcomb.sv
module xnih_extcomb #(
    parameter int unsigned N_NODES       = 4,
    parameter int unsigned MEZZ_PER_NODE = 2,
    parameter int unsigned LINK_LINES    = 4
) (
    input  logic [N_NODES*MEZZ_PER_NODE-1:0] mezz_int_n,
    input  logic [LINK_LINES-1:0]            link_int_n,
    output logic [N_NODES-1:0]               mezz_irq,
    output logic                             link_irq
);

    for (genvar k = 0; k < N_NODES; k++) begin : g_mezz
        assign mezz_irq[k] = ~&mezz_int_n[k*MEZZ_PER_NODE +: MEZZ_PER_NODE];
    end

    assign link_irq = ~&link_int_n;

endmodule

// File: rtl/xnode_irq_hub.sv
module xnode_irq_hub
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES       = 4,
    parameter int unsigned MEZZ_PER_NODE = 2,
    parameter int unsigned LINK_LINES    = 4,
    localparam int unsigned IDX_W        = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_wr_en,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    input  logic [IDX_W-1:0]                 reg_node,
    output logic [DATA_W-1:0]                reg_rdata,
    input  logic [N_NODES-1:0]               bus_err_set,
    input  logic [IPL_W-1:0]                 ctrl_ipl_n,
    input  logic [N_NODES*MEZZ_PER_NODE-1:0] mezz_int_n,
    input  logic [LINK_LINES-1:0]            link_int_n,
    output logic [N_NODES-1:0]               node_irq,
    output logic [N_NODES-1:0]               mezz_irq,
    output logic                             link_irq
);

    reg_wr_t            req;
    reg_sel_e           sel;
    logic [IDX_W-1:0]   db_idx;
    logic [N_NODES-1:0] db_q;
    logic [N_NODES-1:0] err_q;
    logic [N_NODES-1:0] en_q;
    logic [N_NODES-1:0] id_q;
    logic               ctrl_irq;

    assign req.wr   = reg_wr_en;
    assign req.data = reg_wdata;

    xnih_decode #(.N_NODES(N_NODES)) u_dec (
        .addr   (reg_addr),
        .sel    (sel),
        .db_idx (db_idx)
    );

    xnih_doorbells #(.N_NODES(N_NODES)) u_bell (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .sel    (sel),
        .db_idx (db_idx),
        .db_q   (db_q)
    );

    xnih_buserr #(.N_NODES(N_NODES)) u_err (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .sel     (sel),
        .node    (reg_node),
        .err_set (bus_err_set),
        .err_q   (err_q)
    );

    xnih_ctlregs #(.N_NODES(N_NODES)) u_ctl (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .sel  (sel),
        .node (reg_node),
        .en_q (en_q),
        .id_q (id_q)
    );

    xnih_extcomb #(
        .N_NODES       (N_NODES),
        .MEZZ_PER_NODE (MEZZ_PER_NODE),
        .LINK_LINES    (LINK_LINES)
    ) u_ext (
        .mezz_int_n (mezz_int_n),
        .link_int_n (link_int_n),
        .mezz_irq   (mezz_irq),
        .link_irq   (link_irq)
    );

    assign ctrl_irq = ipl_active(ctrl_ipl_n);
    assign node_irq = db_q | err_q | (en_q & {N_NODES{ctrl_irq}});

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: begin
                reg_rdata[ST_IPL_LSB +: IPL_W]   = ctrl_ipl_n;
                reg_rdata[ST_DB_LSB  +: N_NODES] = db_q;
                reg_rdata[ST_ERR_LSB +: N_NODES] = err_q;
            end
            SEL_DOORBELL: reg_rdata[0]           = db_q[db_idx];
            SEL_ENABLE:   reg_rdata[N_NODES-1:0] = en_q;
            SEL_ID:       reg_rdata[N_NODES-1:0] = id_q;
            default:      reg_rdata              = '0;
        endcase
    end

endmodule

// File: rtl/xnode_irq_hub_chk.sv
module xnode_irq_hub_chk
    import xnih_pkg::*;
#(
    parameter int unsigned N_NODES = 4,
    localparam int unsigned IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [IDX_W-1:0]   reg_node,
    input logic [N_NODES-1:0] bus_err_set,
    input logic [IPL_W-1:0]   ctrl_ipl_n,
    input logic [N_NODES-1:0] node_irq,
    input logic [N_NODES-1:0] db_q,
    input logic [N_NODES-1:0] err_q,
    input logic [N_NODES-1:0] id_q
);

    logic rst_seen = 1'b0;

    always @(posedge clk) begin
        if (rst_seen && !rst && (ctrl_ipl_n == 3'b111)) begin
            AST_RESET_QUIET: assert (node_irq == '0); // R1
        end
        rst_seen <= rst;
    end

    for (genvar k = 0; k < N_NODES; k++) begin : g_bell_chk
        AST_DOORBELL_RAISE: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_en && reg_addr == doorbell_ofs(k) && reg_wdata[0])
            |=> node_irq[k]); // R2
        AST_DOORBELL_DROP: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_en && reg_addr == doorbell_ofs(k) && !reg_wdata[0])
            |=> !db_q[k]); // R2
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
            bus_err_set[k] |=> (err_q[k] && node_irq[k])); // R4
    end

    AST_ERR_CLEAR_OWN: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == OFS_STATUS && reg_wdata == BERR_CLEAR_KEY
         && bus_err_set == '0)
        |=> (err_q == ($past(err_q) & ~(N_NODES'(1) << $past(reg_node))))); // R5

    AST_ID_OTHERS_HELD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == OFS_ID)
        |=> (((id_q ^ $past(id_q)) & ~(N_NODES'(1) << $past(reg_node))) == '0)); // R7

endmodule

bind xnode_irq_hub xnode_irq_hub_chk #(.N_NODES(N_NODES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_node    (reg_node),
    .bus_err_set (bus_err_set),
    .ctrl_ipl_n  (ctrl_ipl_n),
    .node_irq    (node_irq),
    .db_q        (db_q),
    .err_q       (err_q),
    .id_q        (id_q)
);

// File: tb/xnode_irq_hub_test.sv
`timescale 1ns/1ps
module xnode_irq_hub_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [1:0]  reg_node = 2'd0;
    logic [31:0] reg_rdata;
    logic [3:0]  bus_err_set = 4'h0;
    logic [2:0]  ctrl_ipl_n = 3'b111;
    logic [7:0]  mezz_int_n = 8'hFF;
    logic [3:0]  link_int_n = 4'hF;
    logic [3:0]  node_irq;
    logic [3:0]  mezz_irq;
    logic        link_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xnode_irq_hub uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_node(reg_node), .reg_rdata(reg_rdata),
        .bus_err_set(bus_err_set), .ctrl_ipl_n(ctrl_ipl_n),
        .mezz_int_n(mezz_int_n), .link_int_n(link_int_n),
        .node_irq(node_irq), .mezz_irq(mezz_irq), .link_irq(link_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] node, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_node = node; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [31:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 node_irq after reset", 32'(node_irq), 32'h0);
        rd(8'h00, d); chk("R1 status after reset", d, 32'h0000_0007);
        rd(8'h1C, d); chk("R1 id after reset", d, 32'h0);
        rd(8'h14, d); chk("R1 enable after reset", d, 32'h0);
    endtask

    task automatic t_doorbell;
        logic [31:0] d;
        wr(2'd1, 8'h04, 32'hFFFF_FFFE);
        chk("R2 upper bits ignored", 32'(node_irq), 32'h0);
        wr(2'd0, 8'h08, 32'h1);
        chk("R2 R8 doorbell node1 raised", 32'(node_irq), 32'h2);
        rd(8'h08, d); chk("R2 doorbell readback", d, 32'h1);
        rd(8'h00, d); chk("R3 status doorbell field", d, 32'h0000_0207);
        wr(2'd3, 8'h10, 32'h1);
        chk("R2 doorbell node3 raised", 32'(node_irq), 32'hA);
        wr(2'd2, 8'h08, 32'h0);
        chk("R2 doorbell node1 cleared", 32'(node_irq), 32'h8);
        wr(2'd2, 8'h10, 32'h0);
        chk("R2 doorbell node3 cleared", 32'(node_irq), 32'h0);
    endtask

    task automatic t_buserr;
        logic [31:0] d;
        @(negedge clk); bus_err_set = 4'b0101;
        @(negedge clk); bus_err_set = 4'b0000;
        chk("R4 R8 bus errors raise irq", 32'(node_irq), 32'h5);
        rd(8'h00, d); chk("R3 status error field", d, 32'h0005_0007);
        wr(2'd1, 8'h00, 32'h10);
        chk("R5 clear by non-owner no effect", 32'(node_irq), 32'h5);
        wr(2'd0, 8'h00, 32'h11);
        chk("R5 wrong key no effect", 32'(node_irq), 32'h5);
        wr(2'd0, 8'h00, 32'h10);
        chk("R5 owner clear", 32'(node_irq), 32'h4);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_node = 2'd2; reg_addr = 8'h00; reg_wdata = 32'h10;
        bus_err_set = 4'b0100;
        @(negedge clk);
        reg_wr_en = 1'b0; bus_err_set = 4'b0000;
        chk("R5 set wins over clear", 32'(node_irq), 32'h4);
        wr(2'd2, 8'h00, 32'h10);
        chk("R5 node2 cleared", 32'(node_irq), 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(2'd0, 8'h14, 32'hFFFF_FFF5);
        rd(8'h14, d); chk("R6 enable readback", d, 32'h5);
        @(negedge clk); ctrl_ipl_n = 3'b101;
        #1 chk("R6 controller irq gated", 32'(node_irq), 32'h5);
        rd(8'h00, d); chk("R3 status ipl field", d, 32'h0000_0005);
        @(negedge clk); bus_err_set = 4'b1000;
        @(negedge clk); bus_err_set = 4'b0000;
        chk("R6 bus error not gated by enable", 32'(node_irq), 32'hD);
        ctrl_ipl_n = 3'b111;
        #1 chk("R6 idle ipl no controller irq", 32'(node_irq), 32'h8);
        wr(2'd3, 8'h00, 32'h10);
        wr(2'd0, 8'h14, 32'h0);
        @(negedge clk); ctrl_ipl_n = 3'b000;
        #1 chk("R6 all disabled", 32'(node_irq), 32'h0);
        ctrl_ipl_n = 3'b111;
    endtask

    task automatic t_id;
        logic [31:0] d;
        wr(2'd2, 8'h1C, 32'hF);
        rd(8'h1C, d); chk("R7 own bit only", d, 32'h4);
        wr(2'd0, 8'h1C, 32'h0);
        rd(8'h1C, d); chk("R7 other bit kept", d, 32'h4);
        wr(2'd0, 8'h1C, 32'h1);
        rd(8'h1C, d); chk("R7 node0 bit set", d, 32'h5);
        wr(2'd2, 8'h1C, 32'h0);
        rd(8'h1C, d); chk("R7 node2 bit cleared", d, 32'h1);
    endtask

    task automatic t_mezz;
        #1 chk("R9 idle", 32'(mezz_irq), 32'h0);
        mezz_int_n = 8'b1111_0111;
        #1 chk("R9 node1 second line", 32'(mezz_irq), 32'h2);
        mezz_int_n = 8'b1011_0111;
        #1 chk("R9 node3 first line", 32'(mezz_irq), 32'hA);
        mezz_int_n = 8'b1111_1100;
        #1 chk("R9 node0 both lines", 32'(mezz_irq), 32'h1);
        mezz_int_n = 8'hFF;
        #1 chk("R9 released, no latch", 32'(mezz_irq), 32'h0);
    endtask

    task automatic t_link;
        #1 chk("R10 idle", 32'(link_irq), 32'h0);
        for (int i = 0; i < 4; i++) begin
            link_int_n = ~(4'b1 << i);
            #1 chk("R10 single line low", 32'(link_irq), 32'h1);
        end
        link_int_n = 4'hF;
        #1 chk("R10 released", 32'(link_irq), 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(2'd1, 8'h18, 32'hFFFF_FFFF);
        wr(2'd1, 8'h20, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R11 unmapped 0x18 reads 0", d, 32'h0);
        rd(8'h20, d); chk("R11 unmapped 0x20 reads 0", d, 32'h0);
        rd(8'h00, d); chk("R11 status unchanged", d, 32'h0000_0007);
        rd(8'h14, d); chk("R11 enable unchanged", d, 32'h0);
        rd(8'h1C, d); chk("R11 id unchanged", d, 32'h1);
        chk("R11 node_irq unchanged", 32'(node_irq), 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_doorbell();
        t_buserr();
        t_enable();
        t_id();
        t_mezz();
        t_link();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule